// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Controller

This block is a synthesizable behavioural model of a small byte-wide memory that can be programmed only once. The array holds 2^AW bytes (256 by default). A synchronous reset stands in for an erase and sets every bit to one. Programming can then only clear bits. The controller looks at the active-low chip select, output gate and program strobe. It also takes two level flags: one says the programming supply is raised, and one says the identifier address line carries a high voltage. From these inputs it picks one operating mode: read, output off, standby, program, program verify, program inhibit or identifier readout.

The data bus is split into a write-data input, a read-data output and a drive-enable output. When the block is not driving, the read-data output is zero. A program operation is triggered by the falling edge of the strobe, sampled on the clock. That edge ANDs the write data into the addressed byte once. The identifier mode returns two fixed bytes, chosen by address bit 0. Each of these bytes carries odd parity in bit 7.

Top module: `otp_mode_ctrl`

## Requirements
- R1: After reset every address reads 8'hFF in read mode.
- R2: Read mode (cs_n=0, oe_n=0, supply flag 0, identifier flag 0) sets dout_en=1 and dout to the byte stored at addr, in the same cycle.
- R3: With cs_n=0 and oe_n=1, dout_en is 0 and dout is 0 whatever the other inputs are.
- R4: With cs_n=1, dout_en is 0 and dout is 0 whatever oe_n, the strobe and the flags are (standby, or program inhibit when the supply flag is set).
- R5: When a clock edge sees strb_n go from 1 to 0 with cs_n=0, supply flag 1 and identifier flag 0, the addressed byte becomes its old value AND din. This is visible from the next cycle, and happens once per falling edge: holding strb_n low longer does nothing more. The outputs stay undriven while the strobe is low in this mode.
- R6: Programming never turns a stored 0 into a 1.
- R7: A strobe falling edge while cs_n=1 changes no stored byte.
- R8: A strobe falling edge while the supply flag is 0 changes no stored byte.
- R9: Verify mode (cs_n=0, oe_n=0, strb_n=1, supply flag 1) drives the stored byte with dout_en=1.
- R10: With cs_n=0, oe_n=0 and the identifier flag set, dout is the maker byte (8'hC2 by default) when addr[0]=0 and the device byte (8'h0E by default) when addr[0]=1. All other address bits are ignored.
- R11: Both identifier bytes hold an odd number of ones, and bit 7 is the parity bit over bits 6:0.
- R12: A strobe falling edge while the identifier flag is set changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; erases the array to all ones |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| strb_n | input | 1 | Program strobe, active low; acts on its falling edge |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | High voltage present on the identifier address line |
| addr | input | AW | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Read data; zero when not driven |
| dout_en | output | 1 | Data bus drive enable |

## Verification
The assertions check four things on every cycle. First, chip deselect and a raised output gate always leave the bus undriven. Second, an active program strobe never coincides with a driven bus. Third, any driven identifier byte has odd parity. Fourth, a stored byte never gains a one: it stays unchanged after any cycle in which the chip was deselected, the supply was low or the identifier flag was set. Other properties can only be shown by the bench's address sweeps and pulse sequences. These are the exact value written by each AND, the single write per strobe edge while the strobe is held low, and the selection of the identifier byte by addr[0] alone.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int DW = 8;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_INHIBIT,
        M_OUTOFF,
        M_READ,
        M_PROGRAM,
        M_VERIFY,
        M_IDENT
    } mode_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic strb_n;
        logic vpp_hi;
        logic id_hv;
    } ctl_t;

    typedef struct packed {
        mode_e mode;
        logic  drive;
        logic  use_id;
        logic  wr_ok;
    } dec_t;

    // Build an identifier byte: bit 7 makes the total count of ones odd.
    function automatic word_t odd_par(input logic [DW-2:0] raw);
        return {~^raw, raw};
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  ctl_t ctl,
    output dec_t dec
);
    always_comb begin
        dec.mode   = M_OUTOFF;
        dec.drive  = 1'b0;
        dec.use_id = 1'b0;
        dec.wr_ok  = 1'b0;
        if (ctl.cs_n) begin
            dec.mode = ctl.vpp_hi ? M_INHIBIT : M_STANDBY;
        end else if (ctl.id_hv) begin
            if (!ctl.oe_n) begin
                dec.mode   = M_IDENT;
                dec.drive  = 1'b1;
                dec.use_id = 1'b1;
            end
        end else if (ctl.vpp_hi && !ctl.strb_n) begin
            dec.mode  = M_PROGRAM;
            dec.wr_ok = 1'b1;
        end else if (!ctl.oe_n) begin
            dec.mode  = ctl.vpp_hi ? M_VERIFY : M_READ;
            dec.drive = 1'b1;
        end
    end
endmodule

// File: rtl/otp_strobe_edge.sv
module otp_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    input  logic wr_ok,
    output logic wr_pulse
);
    logic strb_q;

    // Reset to low so a strobe already held low at reset exit is not an edge.
    always_ff @(posedge clk) begin
        if (rst) strb_q <= 1'b0;
        else     strb_q <= strb_n;
    end

    assign wr_pulse = strb_q & ~strb_n & wr_ok;
endmodule

// File: rtl/otp_array.sv
module otp_array
    import otp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    word_t rows [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows[i] <= '1;
            end else if (wr && (addr == AW'(i))) begin
                rows[i] <= rows[i] & wdata;
            end
        end
    end

    assign rdata = rows[addr];
endmodule

// File: rtl/otp_out_mux.sv
module otp_out_mux
    import otp_pkg::*;
#(
    parameter logic [DW-2:0] MFR_RAW = 7'h42,
    parameter logic [DW-2:0] DEV_RAW = 7'h0E
) (
    input  dec_t  dec,
    input  logic  id_sel,
    input  word_t arr_data,
    output word_t dout,
    output logic  dout_en
);
    localparam word_t MFR_BYTE = odd_par(MFR_RAW);
    localparam word_t DEV_BYTE = odd_par(DEV_RAW);

    word_t id_byte;

    assign id_byte = id_sel ? DEV_BYTE : MFR_BYTE;
    assign dout_en = dec.drive;

    always_comb begin
        if (!dec.drive)      dout = '0;
        else if (dec.use_id) dout = id_byte;
        else                 dout = arr_data;
    end
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl
    import otp_pkg::*;
#(
    parameter int            AW      = 8,
    parameter logic [DW-2:0] MFR_RAW = 7'h42,
    parameter logic [DW-2:0] DEV_RAW = 7'h0E
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          strb_n,
    input  logic          vpp_hi,
    input  logic          id_hv,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          dout_en
);
    ctl_t  ctl;
    dec_t  dec;
    logic  wr_pulse;
    word_t rd_byte;

    assign ctl = '{cs_n: cs_n, oe_n: oe_n, strb_n: strb_n,
                   vpp_hi: vpp_hi, id_hv: id_hv};

    otp_mode_decode u_dec (
        .ctl (ctl),
        .dec (dec)
    );

    otp_strobe_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .strb_n   (strb_n),
        .wr_ok    (dec.wr_ok),
        .wr_pulse (wr_pulse)
    );

    otp_array #(.AW(AW)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_pulse),
        .addr  (addr),
        .wdata (din),
        .rdata (rd_byte)
    );

    otp_out_mux #(.MFR_RAW(MFR_RAW), .DEV_RAW(DEV_RAW)) u_mux (
        .dec      (dec),
        .id_sel   (addr[0]),
        .arr_data (rd_byte),
        .dout     (dout),
        .dout_en  (dout_en)
    );
endmodule

// File: rtl/otp_mode_ctrl_chk.sv
module otp_mode_ctrl_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          oe_n,
    input logic          strb_n,
    input logic          vpp_hi,
    input logic          id_hv,
    input logic [AW-1:0] addr,
    input logic [7:0]    dout,
    input logic          dout_en,
    input logic [7:0]    rd_byte
);
    a_r4_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!dout_en && dout == 8'h00));

    a_r3_gate_high_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && oe_n) |-> (!dout_en && dout == 8'h00));

    a_r5_no_drive_in_program: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && vpp_hi && !strb_n && !id_hv) |-> !dout_en);

    a_r11_id_odd_parity: assert property (@(posedge clk) disable iff (rst)
        (dout_en && id_hv) |-> (^dout == 1'b1));

    a_r6_never_sets: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(addr)) |-> ((rd_byte & ~$past(rd_byte)) == 8'h00));

    // R7, R8, R12: no write outside an enabled program cycle
    a_r7_r8_r12_blocked_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(addr) && ($past(cs_n) || !$past(vpp_hi) || $past(id_hv)))
        |-> $stable(rd_byte));
endmodule

bind otp_mode_ctrl otp_mode_ctrl_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .strb_n  (strb_n),
    .vpp_hi  (vpp_hi),
    .id_hv   (id_hv),
    .addr    (addr),
    .dout    (dout),
    .dout_en (dout_en),
    .rd_byte (rd_byte)
);

// File: tb/otp_mode_ctrl_bench.sv
module otp_mode_ctrl_bench;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, oe_n = 1'b1, strb_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din  = '0;
    logic [7:0]    dout;
    logic          dout_en;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    otp_mode_ctrl #(.AW(AW)) u_otp_mode_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .strb_n(strb_n),
        .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got en/data %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] id_val(input logic [6:0] raw);
        logic [7:0] b;
        b = {1'b0, raw};
        if ($countones(raw) % 2 == 0) b[7] = 1'b1;
        return b;
    endfunction

    task automatic set_read(input logic [AW-1:0] a);
        @(negedge clk);
        cs_n = 0; oe_n = 0; strb_n = 1; vpp_hi = 0; id_hv = 0; addr = a;
        #5;
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            set_read(AW'(a));
            chk(req, {dout_en, dout}, {1'b1, model[a]});
        end
    endtask

    // one strobe pulse; c/v/h select chip select, supply and identifier flag
    task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d,
                         input logic c, input logic v, input logic h);
        @(negedge clk);
        cs_n = c; oe_n = 1; vpp_hi = v; id_hv = h; addr = a; din = d; strb_n = 1;
        @(negedge clk);
        strb_n = 0;
        #5;
        if (!c && v && !h) chk("R5 bus off in program", {dout_en, dout}, 9'h000);
        @(negedge clk);
        strb_n = 1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 erased state
        read_all("R1 erased");

        // R4 standby/inhibit: every combination with chip deselected
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            cs_n = 1; oe_n = k[0]; strb_n = k[1]; vpp_hi = k[2]; id_hv = k[3]; addr = 8'h3C;
            #5;
            chk("R4 standby", {dout_en, dout}, 9'h000);
        end

        // R3 output gate high
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cs_n = 0; oe_n = 1; strb_n = 1; vpp_hi = k[0]; id_hv = k[1]; addr = AW'(k * 37);
            #5;
            chk("R3 gate off", {dout_en, dout}, 9'h000);
        end

        // R5/R2 program every address, then read back
        for (int a = 0; a < DEPTH; a++) begin
            pulse(AW'(a), 8'(a) ^ 8'h5A, 0, 1, 0);
            model[a] = model[a] & (8'(a) ^ 8'h5A);
        end
        read_all("R2 R5 first pass");

        // R6 second pass with a different pattern including ones over zeros
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] q;
            q = {a[3:0], a[7:4]} | 8'h81;
            pulse(AW'(a), q, 0, 1, 0);
            model[a] = model[a] & q;
        end
        read_all("R6 only clears");

        // R5 one write per edge: change din while strobe stays low
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        @(negedge clk);
        cs_n = 0; oe_n = 1; vpp_hi = 1; id_hv = 0; addr = 8'h21; din = 8'hF0; strb_n = 1;
        @(negedge clk);
        strb_n = 0;
        @(negedge clk);
        din = 8'h0F;
        repeat (3) @(negedge clk);
        strb_n = 1;
        model[8'h21] = 8'hF0;
        set_read(8'h21);
        chk("R5 once per edge", {dout_en, dout}, {1'b1, model[8'h21]});

        // R7 deselected, R8 supply low, R12 identifier flag: no writes
        pulse(8'h40, 8'h00, 1, 1, 0);
        set_read(8'h40);
        chk("R7 inhibit", {dout_en, dout}, 9'h1FF);
        pulse(8'h41, 8'h00, 0, 0, 0);
        set_read(8'h41);
        chk("R8 supply low", {dout_en, dout}, 9'h1FF);
        pulse(8'h42, 8'h00, 0, 1, 1);
        set_read(8'h42);
        chk("R12 id blocks", {dout_en, dout}, 9'h1FF);

        // R9 verify mode
        pulse(8'h77, 8'hA5, 0, 1, 0);
        model[8'h77] = 8'hA5;
        @(negedge clk);
        cs_n = 0; oe_n = 0; strb_n = 1; vpp_hi = 1; id_hv = 0; addr = 8'h77;
        #5;
        chk("R9 verify", {dout_en, dout}, 9'h1A5);
        addr = 8'h21;
        #2;
        chk("R9 verify", {dout_en, dout}, {1'b1, model[8'h21]});

        // R10/R11 identifier sweep over all addresses and both supply states
        for (int a = 0; a < 2 * DEPTH; a++) begin
            logic [7:0] e;
            @(negedge clk);
            cs_n = 0; oe_n = 0; strb_n = 1; vpp_hi = a[AW]; id_hv = 1; addr = AW'(a);
            #5;
            e = a[0] ? id_val(7'h0E) : id_val(7'h42);
            chk("R10 id select", {dout_en, dout}, {1'b1, e});
            chk("R11 id parity", {8'h00, ^dout}, 9'h001);
        end

        @(negedge clk);
        cs_n = 1; oe_n = 1; id_hv = 0; vpp_hi = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule